// File: doc/BRIEF.md
# Command Response Checker

This block watches the card's command line once the host has finished sending a command. The host controller gives it a one-cycle pulse at the command's end bit. With that pulse come the index of the issued command, a flag that says whether a response is expected, and two flags that turn the CRC and index checks on or off for this command. The block then waits for the response start bit and shifts in a 48-bit short response, MSB first, at one line bit per clock. It checks the response's CRC7, its end bit and the echoed command index, and it reports the result with single-cycle pulses.

When no response is expected, the block signals completion right after the command end and runs no timeout. Otherwise, if the line stays high for 64 sampled bits after the command end, the block raises a timeout and gives no completion for that command. Long 136-bit responses, command serialization and decoding of the card status bits are handled elsewhere.

Top module: `cmd_rsp_checker`

## Requirements
- R1: After reset, all outputs are 0: `rsp_done`, `rsp_word` and the four error pulses.
- R2: When a response is expected and `cmd_line` samples 1 on all 64 clock edges after the edge that samples `cmd_end`, `err_timeout` goes high for exactly one cycle, starting right after the 64th of those edges. No `rsp_done` is produced for that command.
- R3: A start bit (a 0) sampled on the 64th edge after `cmd_end` is accepted, and no timeout is raised.
- R4: A response is 48 bits, sent MSB first: start 0, transmission bit 0, index in bits [45:40], argument in bits [39:8], CRC7 in bits [7:1], end bit 1 in bit [0]. The end bit is sampled on some edge. `rsp_done` then pulses for one cycle, starting right after the next edge, and `rsp_word` holds the 48 sampled bits at that time.
- R5: The CRC7 uses the polynomial x^7+x^3+1 over bits [47:8], starting from 0. When `crc_chk_en` was high at `cmd_end` and bits [7:1] differ from this CRC7, `err_crc` pulses together with `rsp_done`.
- R6: When `crc_chk_en` was low at `cmd_end`, a CRC mismatch raises no `err_crc`.
- R7: A 0 in the end-bit position raises `err_endbit` together with `rsp_done`.
- R8: When `idx_chk_en` was high at `cmd_end` and bits [45:40] differ from `cmd_idx`, `err_index` pulses with `rsp_done`. When it was low, a mismatch raises no error.
- R9: When `rsp_expected` is low at `cmd_end`, `rsp_done` pulses right after that edge. No timeout follows, and later line activity produces no pulse.
- R10: A correct response with both checks enabled produces `rsp_done` with no error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one command-line bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_end | input | 1 | One-cycle pulse at the issued command's end bit |
| rsp_expected | input | 1 | A response follows the command (sampled at `cmd_end`) |
| crc_chk_en | input | 1 | Enable CRC7 check (sampled at `cmd_end`) |
| idx_chk_en | input | 1 | Enable index echo check (sampled at `cmd_end`) |
| cmd_idx | input | 6 | Index of the issued command (sampled at `cmd_end`) |
| cmd_line | input | 1 | Sampled command line, idle high |
| rsp_done | output | 1 | Pulse: command finished (response received, or none expected) |
| rsp_word | output | 48 | Captured response, valid with `rsp_done` |
| err_timeout | output | 1 | Pulse: no start bit within 64 bits |
| err_crc | output | 1 | Pulse: CRC7 mismatch |
| err_endbit | output | 1 | Pulse: end bit sampled as 0 |
| err_index | output | 1 | Pulse: echoed index differs from issued index |

## Verification
The bench sends responses with different indices, arguments and start gaps, and checks the captured word and that no error is flagged. It then corrupts one field at a time (a CRC bit, the end bit, the index) with the matching enable on and then off, so each error is traced to its own cause and its gating. Two gap lengths test the timeout edge: a start bit on the 64th sample must be accepted, while 64 idle samples must time out. A command with no response checks that completion comes at once and that later line traffic is ignored.

// File: rtl/cmd_rsp_pkg.sv
// Shared types and constants for the command response checker.
package cmd_rsp_pkg;
    localparam int RSP_BITS = 48;
    localparam int CRC_W    = 7;
    localparam int IDX_W    = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RECV  = 2'd2,
        ST_CHECK = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/cmd_rsp_crc7.sv
// Serial CRC7 generator, polynomial x^7+x^3+1, zero seed.
// Assumes one data bit per enabled cycle, MSB of the message first.
module cmd_rsp_crc7 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic fb;

    // Feedback is the incoming bit XOR the register's top bit.
    always_comb fb = din ^ crc[W-1];

    // Shift the register and fold in the polynomial taps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc <= '0;
        else if (en)
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? W'(9) : W'(0));
    end
endmodule

// File: rtl/cmd_rsp_timer.sv
// Counts idle line samples while waiting for a start bit.
// Assumes clr is raised at the command end; expire marks the last allowed idle sample.
module cmd_rsp_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Count idle samples, restart at every command end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    // The final idle sample of the window is the one seen at count LIMIT-1.
    always_comb expire = run && (cnt == CW'(LIMIT - 1));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1) || !run);
endmodule

// File: rtl/cmd_rsp_checker.sv
// Command response checker: waits for the start bit, captures a 48-bit response,
// checks CRC7, end bit and index, and enforces the start-bit timeout.
// Assumes one line bit per clock and an idle-high command line.
module cmd_rsp_checker
    import cmd_rsp_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_end,
    input  logic                rsp_expected,
    input  logic                crc_chk_en,
    input  logic                idx_chk_en,
    input  logic [IDX_W-1:0]    cmd_idx,
    input  logic                cmd_line,
    output logic                rsp_done,
    output logic [RSP_BITS-1:0] rsp_word,
    output logic                err_timeout,
    output logic                err_crc,
    output logic                err_endbit,
    output logic                err_index
);
    localparam int BCW      = $clog2(RSP_BITS + 1);
    localparam int CRC_SPAN = RSP_BITS - CRC_W - 1;
    localparam int IDX_LSB  = RSP_BITS - 2 - IDX_W;

    rsp_state_t          state;
    logic [RSP_BITS-1:0] shreg;
    logic [BCW-1:0]      bitcnt;
    logic                crc_en_q, idx_en_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CRC_W-1:0]    crc_val;
    logic                crc_step, timer_run, timer_expire, sampling;

    // A bit is taken into the response on the start bit and on each receive cycle.
    always_comb begin
        sampling  = (state == ST_WAIT && !cmd_line) || (state == ST_RECV);
        crc_step  = sampling && (bitcnt < BCW'(CRC_SPAN));
        timer_run = (state == ST_WAIT) && cmd_line && !cmd_end;
    end

    cmd_rsp_crc7 #(.W(CRC_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(cmd_end),
        .en(crc_step), .din(cmd_line), .crc(crc_val)
    );

    cmd_rsp_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(cmd_end),
        .run(timer_run), .expire(timer_expire)
    );

    // Sequence the wait, receive and check phases and latch per-command settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            crc_en_q <= 1'b0;
            idx_en_q <= 1'b0;
            idx_q    <= '0;
        end else if (cmd_end) begin
            state    <= rsp_expected ? ST_WAIT : ST_IDLE;
            bitcnt   <= '0;
            crc_en_q <= crc_chk_en;
            idx_en_q <= idx_chk_en;
            idx_q    <= cmd_idx;
        end else begin
            if (sampling) begin
                shreg  <= {shreg[RSP_BITS-2:0], cmd_line};
                bitcnt <= bitcnt + 1'b1;
            end
            case (state)
                ST_WAIT:  if (!cmd_line) state <= ST_RECV;
                          else if (timer_expire) state <= ST_IDLE;
                ST_RECV:  if (bitcnt == BCW'(RSP_BITS - 1)) state <= ST_CHECK;
                ST_CHECK: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Drive the result pulses and the captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done    <= 1'b0;
            rsp_word    <= '0;
            err_timeout <= 1'b0;
            err_crc     <= 1'b0;
            err_endbit  <= 1'b0;
            err_index   <= 1'b0;
        end else begin
            rsp_done    <= (cmd_end && !rsp_expected) || (!cmd_end && state == ST_CHECK);
            err_timeout <= !cmd_end && timer_expire;
            err_crc     <= !cmd_end && state == ST_CHECK && crc_en_q && (shreg[CRC_W:1] != crc_val);
            err_endbit  <= !cmd_end && state == ST_CHECK && !shreg[0];
            err_index   <= !cmd_end && state == ST_CHECK && idx_en_q &&
                           (shreg[IDX_LSB +: IDX_W] != idx_q);
            if (!cmd_end && state == ST_CHECK)
                rsp_word <= shreg;
        end
    end

    p_timeout_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> !err_timeout);
    p_timeout_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !rsp_done);
    p_errs_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_crc || err_endbit || err_index) |-> rsp_done);
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !$past(cmd_end)) |=> !rsp_done || $past(cmd_end));
    p_crc_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_crc) |-> $past(crc_en_q));
    p_idx_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_index) |-> $past(idx_en_q));
    p_noexp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && !rsp_expected) |=> state == ST_IDLE);
endmodule

// File: tb/tb_cmd_rsp_checker.sv
module tb_cmd_rsp_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_end = 1'b0, rsp_expected = 1'b1, crc_chk_en = 1'b1, idx_chk_en = 1'b1;
    logic [5:0]  cmd_idx = '0;
    logic        cmd_line = 1'b1;
    logic        rsp_done, err_timeout, err_crc, err_endbit, err_index;
    logic [47:0] rsp_word;
    int          n_run = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    cmd_rsp_checker dut (
        .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .rsp_expected(rsp_expected),
        .crc_chk_en(crc_chk_en), .idx_chk_en(idx_chk_en), .cmd_idx(cmd_idx),
        .cmd_line(cmd_line), .rsp_done(rsp_done), .rsp_word(rsp_word),
        .err_timeout(err_timeout), .err_crc(err_crc), .err_endbit(err_endbit),
        .err_index(err_index)
    );

    function automatic logic [6:0] crc7(input logic [39:0] m);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic f = m[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_rsp(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] head = {2'b00, idx, arg};
        return {head, crc7(head), 1'b1};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pulse cmd_end with the given settings; returns at the negedge after the sampling edge.
    task automatic issue(input logic exp, input logic cen, input logic ien, input logic [5:0] idx);
        @(negedge clk);
        cmd_end = 1'b1; rsp_expected = exp; crc_chk_en = cen; idx_chk_en = ien; cmd_idx = idx;
        @(negedge clk);
        cmd_end = 1'b0;
    endtask

    // Drive gap idle bits then the word; returns at the negedge where results show.
    task automatic send(input int gap, input logic [47:0] w);
        for (int i = 0; i < gap; i++) begin cmd_line = 1'b1; @(negedge clk); end
        for (int i = 47; i >= 0; i--) begin cmd_line = w[i]; @(negedge clk); end
        cmd_line = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 done", rsp_done, 0); chk("R1 word", rsp_word, 0);
        chk("R1 errs", {err_timeout, err_crc, err_endbit, err_index}, 0);
    endtask

    task automatic t_good(input logic [5:0] idx, input logic [31:0] arg, input int gap);
        logic [47:0] w = mk_rsp(idx, arg);
        issue(1, 1, 1, idx);
        send(gap, w);
        chk("R4 done", rsp_done, 1); chk("R4 word", rsp_word, w);
        chk("R10 no err", {err_timeout, err_crc, err_endbit, err_index}, 0);
        @(negedge clk);
        chk("R4 single pulse", rsp_done, 0);
    endtask

    task automatic t_timeout;
        logic seen_done = 1'b0;
        issue(1, 1, 1, 6'd3);
        for (int i = 0; i < 63; i++) begin
            cmd_line = 1'b1; @(negedge clk);
            if (err_timeout) chk("R2 early timeout", 1, 0);
        end
        cmd_line = 1'b1; @(negedge clk);
        chk("R2 timeout", err_timeout, 1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rsp_done) seen_done = 1'b1;
            if (i == 0) chk("R2 timeout pulse", err_timeout, 0);
        end
        chk("R2 no done", seen_done, 0);
    endtask

    task automatic t_late_start;
        logic [47:0] w = mk_rsp(6'd9, 32'hDEADBEEF);
        logic to = 1'b0;
        issue(1, 1, 1, 6'd9);
        for (int i = 0; i < 63; i++) begin cmd_line = 1'b1; @(negedge clk); end
        for (int i = 47; i >= 0; i--) begin
            cmd_line = w[i]; @(negedge clk);
            if (err_timeout) to = 1'b1;
        end
        cmd_line = 1'b1; @(negedge clk);
        chk("R3 no timeout", to, 0); chk("R3 done", rsp_done, 1); chk("R3 word", rsp_word, w);
    endtask

    task automatic t_crc(input logic en);
        logic [47:0] w = mk_rsp(6'd17, 32'h0000_0900) ^ 48'h4;
        issue(1, en, 1, 6'd17);
        send(5, w);
        chk(en ? "R5 crc err" : "R6 crc ignored", err_crc, en);
        chk("R5 done", rsp_done, 1);
    endtask

    task automatic t_endbit;
        logic [47:0] w = mk_rsp(6'd13, 32'h1234_5678) & ~48'h1;
        issue(1, 1, 1, 6'd13);
        send(2, w);
        chk("R7 endbit", err_endbit, 1); chk("R7 done", rsp_done, 1);
        chk("R7 crc ok", err_crc, 0);
    endtask

    task automatic t_index(input logic en);
        issue(1, 1, en, 6'd7);
        send(4, mk_rsp(6'd8, 32'hA5A5_0001));
        chk(en ? "R8 idx err" : "R8 idx ignored", err_index, en);
        chk("R8 done", rsp_done, 1);
    endtask

    task automatic t_no_rsp;
        logic any = 1'b0;
        issue(0, 1, 1, 6'd0);
        chk("R9 immediate done", rsp_done, 1);
        for (int i = 0; i < 120; i++) begin
            cmd_line = (i % 3 == 0) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (rsp_done || err_timeout || err_crc || err_endbit || err_index) any = 1'b1;
        end
        cmd_line = 1'b1;
        chk("R9 no later pulse", any, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good(6'd17, 32'h0000_0900, 0);
        t_good(6'd55, 32'hFFFF_FFFF, 10);
        t_good(6'd0, 32'h0, 1);
        t_timeout();
        t_late_start();
        t_crc(1);
        t_crc(0);
        t_endbit();
        t_index(1);
        t_index(0);
        t_no_rsp();
        t_good(6'd41, 32'h8000_0001, 30);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule